// File: doc/BRIEF.md
# Enable-Pulse Reference Code Programmer

This block turns one synchronized enable line into a reference setting and an on/off state for a single regulator channel. While the line is high, each short low pulse moves an internal 4-bit step counter down by one. The counter starts at full scale. How long the line then stays at one level decides what happens next. A high level held for the high timeout loads the counter into the output code, turns the channel on and returns the counter to full scale. A low level held for the low timeout turns the channel off and also returns the counter to full scale.

Both timeouts are parameters counted in system clock cycles. The block reports the committed code and the reference in millivolts, which is 425 mV plus 25 mV per code step, or 0 mV while the channel is off. It also reports a channel-on flag and a one-cycle soft-start request. A chip with three channels uses three instances.

Top module: `enpc_ref_prog`

## Requirements
- R1: After reset the channel is off, `code_o` is 15, `ref_mv_o` is 0 and `ss_req_o` is low.
- R2: Each cycle in which `en_i` is sampled low after being sampled high moves the step counter down by one. A commit after N such falls from full scale gives code 15-N.
- R3: A step below code 0 wraps to 15. Sixteen falls give code 15 and seventeen give code 14.
- R4: When `en_i` has been sampled high on HI_CYC consecutive rising clock edges (the edge that first sees it high counts as one), the counter is loaded into `code_o` and `on_o` is set on that edge. After HI_CYC-1 such edges, nothing has been loaded yet.
- R5: A commit returns the step counter to 15, so the next commit counts from full scale again.
- R6: When `en_i` has been sampled low on LO_CYC consecutive edges, `on_o` clears and the step counter returns to 15. Falls seen before that are discarded, and `code_o` keeps its value. A low run of LO_CYC-1 edges leaves `on_o` set.
- R7: `ref_mv_o` equals 425 + 25·`code_o` while `on_o` is high, and 0 while it is low.
- R8: `ss_req_o` is high for exactly one cycle, and only in the cycle in which `on_o` first goes high after being off. A commit while the channel is already on does not raise it.
- R9: Both timers restart on every change of `en_i`. A pulse train whose high stretches are each shorter than HI_CYC commits nothing until the final high run reaches HI_CYC.
- R10: Each timeout fires once per run of one level. Holding `en_i` high well past HI_CYC after a commit does not load again, even though the counter is back at 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_i | input | 1 | Synchronized enable/programming line |
| code_o | output | CODE_W (4) | Committed reference code |
| ref_mv_o | output | MV_W (10) | Reference in millivolts, 0 while off |
| on_o | output | 1 | Channel is on |
| ss_req_o | output | 1 | One-cycle soft-start request |

## Verification
A commit and the off-to-on transition can land on the same clock edge. On that edge the code loads, `on_o` rises and `ss_req_o` pulses, all together. The bench provokes this by programming a code from shutdown. It holds the line high for exactly HI_CYC edges and then expects the new code, its millivolt value, `on_o` high and `ss_req_o` high in one sample, and `ss_req_o` low in the next. It also commits a code while the channel is already on, where the load must happen without any soft-start pulse.

// File: rtl/enpc_pkg.sv
// Package: shared event type for the enable-pulse reference programmer.
// Assumes all users agree on the field order of the event struct.
package enpc_pkg;

    // Events that the level timer extracts from the enable line in one cycle.
    typedef struct packed {
        logic fall;     // enable sampled low after being high
        logic hi_tmo;   // high run has just reached the high timeout
        logic lo_tmo;   // low run has just reached the low timeout
    } enpc_evt_t;

endpackage

// File: rtl/enpc_level_timer.sv
// Level timer: finds edges on the synchronized enable line and counts
// how many consecutive edges sampled the same level. It emits a falling
// edge event and one event per run when a run reaches its timeout.
// Assumes en_i is already synchronous and HI_CYC, LO_CYC >= 2.
module enpc_level_timer
    import enpc_pkg::*;
#(
    parameter int HI_CYC = 125,
    parameter int LO_CYC = 170
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      en_i,
    output enpc_evt_t evt_o
);
    localparam int MAXT = (HI_CYC > LO_CYC) ? HI_CYC : LO_CYC;
    localparam int HW   = $clog2(MAXT + 2);
    localparam logic [HW-1:0] SAT = HW'(MAXT + 1);

    logic          en_q;
    logic [HW-1:0] held_q;
    logic [HW-1:0] held_d;

    // Run length including the current sample; saturates above both timeouts.
    always_comb begin
        if (en_i != en_q)
            held_d = HW'(1);
        else if (held_q == SAT)
            held_d = held_q;
        else
            held_d = held_q + HW'(1);
    end

    // Register the previous level and the run length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            held_q <= '0;
        end else begin
            en_q   <= en_i;
            held_q <= held_d;
        end
    end

    // Decode the events of this cycle.
    always_comb begin
        evt_o.fall   = en_q & ~en_i;
        evt_o.hi_tmo = en_i  & (held_d == HW'(HI_CYC));
        evt_o.lo_tmo = ~en_i & (held_d == HW'(LO_CYC));
    end

endmodule

// File: rtl/enpc_step_counter.sv
// Step counter: moves down one code per falling edge and wraps from 0 to
// full scale. It returns to full scale when either timeout fires.
// Assumes a reload and a fall never arrive in the same cycle.
module enpc_step_counter #(
    parameter int CODE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_i,
    input  logic              reload_i,
    output logic [CODE_W-1:0] cnt_o
);
    // Count down on steps (wraps modulo 2**CODE_W); reload to all ones.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_o <= '1;
        else if (reload_i)
            cnt_o <= '1;
        else if (step_i)
            cnt_o <= cnt_o - CODE_W'(1);
    end

endmodule

// File: rtl/enpc_commit_reg.sv
// Commit register: holds the committed code and the on state, and raises
// a one-cycle soft-start request on the transition from off to on.
// Assumes the high and low timeouts are mutually exclusive.
module enpc_commit_reg #(
    parameter int CODE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hi_tmo_i,
    input  logic              lo_tmo_i,
    input  logic [CODE_W-1:0] cnt_i,
    output logic [CODE_W-1:0] code_o,
    output logic              on_o,
    output logic              ss_o
);
    // Load the code and turn on at the high timeout; turn off at the low timeout.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_o <= '1;
            on_o   <= 1'b0;
            ss_o   <= 1'b0;
        end else begin
            ss_o <= hi_tmo_i & ~on_o;
            if (hi_tmo_i) begin
                code_o <= cnt_i;
                on_o   <= 1'b1;
            end else if (lo_tmo_i) begin
                on_o   <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/enpc_ref_prog.sv
// Top: enable-pulse reference programmer for one regulator channel.
// Falling edges on en_i step a code down from full scale. A long high
// commits the code and turns the channel on; a long low turns it off.
// Assumes en_i is synchronized to clk and both timeouts are >= 2 cycles.
module enpc_ref_prog
    import enpc_pkg::*;
#(
    parameter int CODE_W  = 4,
    parameter int HI_CYC  = 125,
    parameter int LO_CYC  = 170,
    parameter int BASE_MV = 425,
    parameter int STEP_MV = 25,
    localparam int FULL   = (1 << CODE_W) - 1,
    localparam int MV_W   = $clog2(BASE_MV + STEP_MV * FULL + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    output logic [CODE_W-1:0] code_o,
    output logic [MV_W-1:0]   ref_mv_o,
    output logic              on_o,
    output logic              ss_req_o
);
    enpc_evt_t         evt;
    logic [CODE_W-1:0] cnt;

    enpc_level_timer #(
        .HI_CYC (HI_CYC),
        .LO_CYC (LO_CYC)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .en_i  (en_i),
        .evt_o (evt)
    );

    enpc_step_counter #(
        .CODE_W (CODE_W)
    ) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .step_i   (evt.fall),
        .reload_i (evt.hi_tmo | evt.lo_tmo),
        .cnt_o    (cnt)
    );

    enpc_commit_reg #(
        .CODE_W (CODE_W)
    ) u_commit (
        .clk      (clk),
        .rst_n    (rst_n),
        .hi_tmo_i (evt.hi_tmo),
        .lo_tmo_i (evt.lo_tmo),
        .cnt_i    (cnt),
        .code_o   (code_o),
        .on_o     (on_o),
        .ss_o     (ss_req_o)
    );

    // Map the committed code to millivolts; zero while the channel is off.
    always_comb begin
        if (on_o)
            ref_mv_o = MV_W'(BASE_MV) + MV_W'(STEP_MV) * MV_W'(code_o);
        else
            ref_mv_o = '0;
    end

endmodule

// File: rtl/enpc_ref_prog_chk.sv
// Checker: temporal properties of the programmer's ports, bound to the top.
// Assumes the same parameters as the instance it is bound to.
module enpc_ref_prog_chk #(
    parameter int CODE_W = 4,
    parameter int MV_W   = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en_i,
    input logic [CODE_W-1:0] code_o,
    input logic [MV_W-1:0]   ref_mv_o,
    input logic              on_o,
    input logic              ss_req_o
);
    p_ss_one_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ss_req_o |=> !ss_req_o);

    p_ss_only_on_turn_on_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ss_req_o |-> (on_o && !$past(on_o)));

    p_turn_on_requests_ss_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(on_o) |-> ss_req_o);

    p_off_ref_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !on_o |-> (ref_mv_o == '0));

    p_code_loads_on_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (code_o != $past(code_o)) |-> $past(en_i));

    p_turn_on_on_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(on_o) |-> $past(en_i));

    p_turn_off_on_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(on_o) |-> !$past(en_i));

endmodule

bind enpc_ref_prog enpc_ref_prog_chk #(
    .CODE_W (CODE_W),
    .MV_W   (MV_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_i     (en_i),
    .code_o   (code_o),
    .ref_mv_o (ref_mv_o),
    .on_o     (on_o),
    .ss_req_o (ss_req_o)
);

// File: tb/enpc_ref_prog_bench.sv
// Scoreboard bench: driver tasks shape the enable line and push expected
// output items; a monitor pops and compares them away from the clock edge.
module enpc_ref_prog_bench;
    localparam int CLK_PERIOD = 10;
    localparam int HI = 125;
    localparam int LO = 170;

    typedef struct {
        string   req;
        int      code;
        bit      on;
        int      mv;
        bit      ss;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic [3:0] code;
    logic [9:0] ref_mv;
    logic       on;
    logic       ss;

    int   n_checks = 0;
    int   n_fail = 0;
    bit   done = 1'b0;
    exp_t q[$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    enpc_ref_prog #(
        .HI_CYC (HI),
        .LO_CYC (LO)
    ) u_enpc_ref_prog (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (en),
        .code_o   (code),
        .ref_mv_o (ref_mv),
        .on_o     (on),
        .ss_req_o (ss)
    );

    // Drive the line at val for n clock edges, ending at a falling clock edge.
    task automatic hold(input bit val, input int n);
        en = val;
        repeat (n) @(negedge clk);
    endtask

    // One programming pulse: one edge low, then one edge high.
    task automatic pulse();
        hold(1'b0, 1);
        hold(1'b1, 1);
    endtask

    // Push an expected output item for the current sample point.
    task automatic expect_out(input string req, input int c, input bit o, input bit s);
        exp_t e;
        e.req  = req;
        e.code = c;
        e.on   = o;
        e.mv   = o ? 425 + 25 * c : 0;
        e.ss   = s;
        q.push_back(e);
    endtask

    // Monitor: compare pending expectations just after each falling clock edge.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                n_checks++;
                if (int'(code) != e.code || on != e.on || int'(ref_mv) != e.mv || ss != e.ss) begin
                    n_fail++;
                    $display("FAIL %s: got code=%0d on=%0b mv=%0d ss=%0b, expected code=%0d on=%0b mv=%0d ss=%0b",
                             e.req, code, on, ref_mv, ss, e.code, e.on, e.mv, e.ss);
                end
            end
        end
    end

    // Watchdog: an expired run counts as a failure and still reports.
    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout, expected end of test");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    // Stimulus.
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        expect_out("R1 reset state", 15, 1'b0, 1'b0);

        // R4: turn-on needs exactly HI high edges; R8 soft-start pulse.
        hold(1'b1, HI - 1);
        expect_out("R4 not yet on", 15, 1'b0, 1'b0);
        hold(1'b1, 1);
        expect_out("R4 R8 turn on at full scale", 15, 1'b1, 1'b1);
        hold(1'b1, 1);
        expect_out("R8 ss single cycle", 15, 1'b1, 1'b0);

        // R2 R5: two pulses from full scale, commit while on without ss.
        pulse();
        pulse();
        hold(1'b1, HI - 2);
        expect_out("R9 not committed early", 15, 1'b1, 1'b0);
        hold(1'b1, 1);
        expect_out("R2 R7 R8 code 13 no ss when on", 13, 1'b1, 1'b0);

        // R10: long high after commit must not reload full scale.
        hold(1'b1, 3 * HI);
        expect_out("R10 no second commit", 13, 1'b1, 1'b0);

        // R9: six pulses with high stretches just under the timeout.
        for (int i = 0; i < 6; i++) begin
            hold(1'b0, 1);
            hold(1'b1, HI - 1);
        end
        expect_out("R9 timers restart on edges", 13, 1'b1, 1'b0);
        hold(1'b1, 1);
        expect_out("R2 R5 R7 code 9", 9, 1'b1, 1'b0);

        // R6: low timeout turns off, code kept.
        hold(1'b0, LO - 1);
        expect_out("R6 short low stays on", 9, 1'b1, 1'b0);
        hold(1'b0, 1);
        expect_out("R6 R7 turned off", 9, 1'b0, 1'b0);

        // R6: falls before a long low are discarded.
        for (int i = 0; i < 3; i++) begin
            hold(1'b1, 1);
            hold(1'b0, 1);
        end
        hold(1'b0, LO);
        expect_out("R6 still off", 9, 1'b0, 1'b0);
        hold(1'b1, HI);
        expect_out("R6 R8 counter reset to full scale", 15, 1'b1, 1'b1);

        // R3: seventeen falls wrap below zero.
        for (int i = 0; i < 17; i++) pulse();
        hold(1'b1, HI - 1);
        expect_out("R3 wrap gives 14", 14, 1'b1, 1'b0);

        // Commit and turn-on on the same edge from shutdown.
        hold(1'b0, LO);
        expect_out("R6 off again", 14, 1'b0, 1'b0);
        hold(1'b1, 1);
        for (int i = 0; i < 4; i++) pulse();
        hold(1'b1, HI - 1);
        expect_out("R4 R8 commit with turn-on code 11", 11, 1'b1, 1'b1);
        hold(1'b1, 1);
        expect_out("R8 ss drops", 11, 1'b1, 1'b0);

        // R6: a low just under the timeout is one fall, not a shutdown.
        hold(1'b0, LO - 1);
        expect_out("R6 low under timeout keeps on", 11, 1'b1, 1'b0);
        hold(1'b1, HI);
        expect_out("R2 R5 one fall gives 14", 14, 1'b1, 1'b0);

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule